// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves each received Ethernet frame from a byte stream into system memory. Where the bytes go is set by descriptors that software places in memory. A descriptor is four 32-bit words, in this order:

- a status word, which holds an ownership bit;
- a control word, which holds two buffer sizes and the link flags;
- the address of buffer 1;
- the address of buffer 2, or the address of the next descriptor when chaining is on.

When a frame starts, the engine reads the current descriptor. If the DMA does not own it, the engine drops the frame. If the DMA owns it, the engine writes the frame bytes into buffer 1 and then into buffer 2. It then writes a status word back over the descriptor, and either moves to the next descriptor or closes the frame.

The engine issues every memory access on a word-wide request port. Each access completes with a one-cycle request/grant handshake. Read data is valid in the grant cycle. Every frame byte is its own single-lane write. The byte stream is held off while that write waits for its grant.

The frame-start handshake carries the payload length. The stream that follows must carry that many bytes plus four check-sequence bytes. The engine counts all of them.

Status is reported on these outputs:
- sticky receive-interrupt (RI) and unavailable (RU) flags;
- a flush flag;
- the current descriptor and buffer pointers;
- a 3-bit process state.

Top module: `rxring_dma`

## Requirements
- R1: After reset the engine is in state 0 (stopped), RI, RU and flush are 0, the descriptor pointer is 0, no memory request is made, and a frame start is accepted.
- R2: A frame start with a zero descriptor pointer first loads the pointer from `base_addr`. The descriptor is then fetched as four word reads at pointer, +4, +8 and +12.
- R3: If the first descriptor of a frame has status bit 31 (ownership) clear, the engine sets RU and RI and moves to state 4 (suspended). It makes no memory write, consumes and discards all length+4 stream bytes, and leaves the pointer unchanged.
- R4: The engine stores length+4 bytes per frame. Each byte is one write at buffer address plus offset, with the byte enable one-hot on address bits 1:0.
- R5: Buffer 1 (address in word 2) is filled up to control bits 10:0. If bytes remain and chaining (control bit 24) is clear, buffer 2 (address in word 3) is filled up to control bits 21:11. `cur_buf` shows the start address of the buffer being filled.
- R6: Write-back replaces the status word of each used descriptor. Bit 31 is 0 and bit 5 (frame type) is 1. Bits 29:16 hold the count of frame bytes stored so far. Bit 9 is set only on the frame's first descriptor and bit 8 only on its last.
- R7: The next descriptor address is chosen in this order. With control bit 25 (end of ring) set, it is `base_addr`. Otherwise, with bit 24 set, it is word 3. Otherwise it is the current address + 16.
- R8: If a descriptor fetched in the middle of a frame is not owned, the frame ends there. That descriptor's status word becomes bit 8, the byte count, and bit 14 (descriptor error) unless flush is set. The remaining stream bytes are discarded, and the pointer moves past that descriptor.
- R9: When a frame closes, RI is set unless control bit 31 (no completion interrupt) of the final descriptor is set. The flush flag is set, and the pointer is left at the next descriptor.
- R10: The process state steps through 1 (fetching), 7 (transferring), 5 (closing) and 3 (waiting). It returns to 1 for each further descriptor of a frame.
- R11: A pulse on `ri_clr` clears RI. A pulse on `flush_clr` clears flush. A pulse on `ru_clr` clears RU and turns a suspended state into waiting.
- R12: A stream byte is accepted only in the cycle its memory write is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_addr | input | ADDR_W | Descriptor list base address |
| frm_valid | input | 1 | Frame start request |
| frm_len | input | LEN_W | Payload length of the frame |
| frm_ready | output | 1 | Frame start accepted (engine idle) |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Stream byte taken |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| ri_clr | input | 1 | Clear RI |
| ru_clr | input | 1 | Clear RU |
| flush_clr | input | 1 | Clear flush flag |
| cur_desc | output | ADDR_W | Current descriptor pointer |
| cur_buf | output | ADDR_W | Current buffer address |
| ri | output | 1 | Receive-complete interrupt flag |
| ru | output | 1 | Descriptor-unavailable flag |
| flush | output | 1 | Flush flag |
| proc_state | output | 3 | Process state code |

## Verification
Some rules are checked by assertions on every cycle:
- a status write-back never hands ownership back to the DMA;
- each data write enables exactly one byte lane;
- a stream byte is taken only together with a granted write;
- RU never rises without RI;
- a suspended drop issues no memory request;
- fetch reads are word aligned.

Other behaviour can only be shown by the directed scenarios, which compare memory contents and the written-back status words with values worked out from the descriptors:
- the split of a frame across two buffers and several descriptors;
- the three ways of choosing the next descriptor;
- the cumulative length field;
- the first and last markers;
- the descriptor-error bit and how the flush flag masks it;
- the order of the process states.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   localparam int BSZ_W   = 11;
   localparam int OWN_B   = 31;
   localparam int FL_LO   = 16;
   localparam int DE_B    = 14;
   localparam int FS_B    = 9;
   localparam int LS_B    = 8;
   localparam int FT_B    = 5;
   localparam int B1_LO   = 0;
   localparam int B2_LO   = 11;
   localparam int CHAIN_B = 24;
   localparam int RING_B  = 25;
   localparam int NOIRQ_B = 31;

   typedef enum logic [2:0] {
      PS_STOP  = 3'd0,
      PS_FETCH = 3'd1,
      PS_WAIT  = 3'd3,
      PS_SUSP  = 3'd4,
      PS_CLOSE = 3'd5,
      PS_XFER  = 3'd7
   } pstate_e;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_XFER, S_WB, S_DRAIN
   } fsm_e;

endpackage

// File: rtl/rxring_next_ptr.sv
module rxring_next_ptr #(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 16
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] link,
   input  logic              ring_end,
   input  logic              chained,
   output logic [ADDR_W-1:0] nxt
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

   always_comb begin
      if (ring_end)     nxt = base;
      else if (chained) nxt = link;
      else              nxt = cur + STEP;
   end
endmodule

// File: rtl/rxring_stat_pack.sv
module rxring_stat_pack
   import rxring_pkg::*;
#(
   parameter int LEN_W = 14
) (
   input  logic [LEN_W-1:0] count,
   input  logic             first,
   input  logic             last,
   input  logic             bad,
   input  logic             flush,
   output logic [31:0]      word
);
   always_comb begin
      word = '0;
      word[FL_LO +: LEN_W] = count;
      word[LS_B] = last;
      if (bad) begin
         word[DE_B] = ~flush;
      end else begin
         word[FT_B] = 1'b1;
         word[FS_B] = first;
      end
   end
endmodule

// File: rtl/rxring_lane_steer.sv
module rxring_lane_steer #(
   parameter int LANES = 4
) (
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic                     full,
   input  logic [7:0]               byte_in,
   input  logic [8*LANES-1:0]       word_in,
   output logic [LANES-1:0]         be,
   output logic [8*LANES-1:0]       wdata
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign be[k] = full | (lane == ($clog2(LANES))'(k));
      assign wdata[8*k +: 8] = full ? word_in[8*k +: 8] : byte_in;
   end
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
   import rxring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 14,
   parameter int STRIDE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              frm_ready,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              byte_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   input  logic              ri_clr,
   input  logic              ru_clr,
   input  logic              flush_clr,
   output logic [ADDR_W-1:0] cur_desc,
   output logic [ADDR_W-1:0] cur_buf,
   output logic              ri,
   output logic              ru,
   output logic              flush,
   output logic [2:0]        proc_state
);
   localparam int REM_W = LEN_W + 1;

   if (LEN_W > 14 || LEN_W < BSZ_W + 1) begin : g_bad_len
      $error("LEN_W must lie between BSZ_W+1 and 14");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 32");
   end
   if (STRIDE < 16 || (STRIDE % 4) != 0) begin : g_bad_stride
      $error("STRIDE must be a word multiple of at least 16");
   end

   fsm_e              st_q;
   pstate_e           pst_q;
   logic [ADDR_W-1:0] ptr_q, buf_q, w2_q, w3_q;
   logic [31:0]       w1_q;
   logic [1:0]        widx_q;
   logic              own_q, first_q, last_q, bad_q;
   logic [REM_W-1:0]  rem_q, cnt_q;
   logic              bsel_q;
   logic [BSZ_W-1:0]  boff_q;
   logic              ri_q, ru_q, flush_q;

   logic [BSZ_W-1:0]  blen;
   logic [ADDR_W-1:0] baddr, nxt_ptr;
   logic              room, data_left;
   logic [31:0]       stat_word, steer_wdata;
   logic [3:0]        steer_be;

   assign blen      = bsel_q ? w1_q[B2_LO +: BSZ_W] : w1_q[B1_LO +: BSZ_W];
   assign baddr     = bsel_q ? w3_q : w2_q;
   assign room      = (boff_q != blen);
   assign data_left = (rem_q != '0);

   rxring_next_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_next (
      .cur(ptr_q), .base(base_addr), .link(w3_q),
      .ring_end(w1_q[RING_B]), .chained(w1_q[CHAIN_B]), .nxt(nxt_ptr)
   );

   rxring_stat_pack #(.LEN_W(LEN_W)) u_stat (
      .count(cnt_q[LEN_W-1:0]), .first(first_q), .last(last_q),
      .bad(bad_q), .flush(flush_q), .word(stat_word)
   );

   rxring_lane_steer #(.LANES(4)) u_steer (
      .lane(mem_addr[1:0]), .full(st_q != S_XFER), .byte_in(byte_data),
      .word_in(stat_word), .be(steer_be), .wdata(steer_wdata)
   );

   always_comb begin
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      byte_ready = 1'b0;
      unique case (st_q)
         S_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = ptr_q + ADDR_W'({widx_q, 2'b00});
         end
         S_XFER: begin
            mem_req    = byte_valid & room & data_left;
            mem_we     = 1'b1;
            mem_addr   = baddr + ADDR_W'(boff_q);
            byte_ready = mem_req & mem_gnt;
         end
         S_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = ptr_q;
         end
         S_DRAIN: byte_ready = data_left;
         default: ;
      endcase
   end

   assign mem_be     = steer_be;
   assign mem_wdata  = steer_wdata;
   assign frm_ready  = (st_q == S_IDLE);
   assign cur_desc   = ptr_q;
   assign cur_buf    = buf_q;
   assign ri         = ri_q;
   assign ru         = ru_q;
   assign flush      = flush_q;
   assign proc_state = pst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE;   pst_q <= PS_STOP;
         ptr_q <= '0;      buf_q <= '0;   w1_q <= '0;  w2_q <= '0;  w3_q <= '0;
         widx_q <= '0;     own_q <= 1'b0; first_q <= 1'b0;
         last_q <= 1'b0;   bad_q <= 1'b0;
         rem_q <= '0;      cnt_q <= '0;   bsel_q <= 1'b0; boff_q <= '0;
         ri_q <= 1'b0;     ru_q <= 1'b0;  flush_q <= 1'b0;
      end else begin
         if (ri_clr)    ri_q <= 1'b0;
         if (flush_clr) flush_q <= 1'b0;
         if (ru_clr) begin
            ru_q <= 1'b0;
            if (pst_q == PS_SUSP) pst_q <= PS_WAIT;
         end
         unique case (st_q)
            S_IDLE: if (frm_valid) begin
               rem_q   <= REM_W'(frm_len) + REM_W'(4);
               cnt_q   <= '0;
               first_q <= 1'b1;
               bad_q   <= 1'b0;
               widx_q  <= '0;
               if (ptr_q == '0) ptr_q <= base_addr;
               st_q  <= S_FETCH;
               pst_q <= PS_FETCH;
            end
            S_FETCH: if (mem_gnt) begin
               widx_q <= widx_q + 2'd1;
               unique case (widx_q)
                  2'd0: own_q <= mem_rdata[OWN_B];
                  2'd1: w1_q  <= mem_rdata;
                  2'd2: w2_q  <= mem_rdata[ADDR_W-1:0];
                  default: w3_q <= mem_rdata[ADDR_W-1:0];
               endcase
               if (widx_q == 2'd3) begin
                  if (own_q) begin
                     st_q   <= S_XFER;
                     pst_q  <= PS_XFER;
                     bsel_q <= 1'b0;
                     boff_q <= '0;
                     buf_q  <= w2_q;
                  end else if (first_q) begin
                     ru_q  <= 1'b1;
                     ri_q  <= 1'b1;
                     pst_q <= PS_SUSP;
                     st_q  <= S_DRAIN;
                  end else begin
                     bad_q  <= 1'b1;
                     last_q <= 1'b1;
                     pst_q  <= PS_CLOSE;
                     st_q   <= S_WB;
                  end
               end
            end
            S_XFER: begin
               if (!data_left) begin
                  last_q <= 1'b1;
                  pst_q  <= PS_CLOSE;
                  st_q   <= S_WB;
               end else if (!room) begin
                  if (!bsel_q && !w1_q[CHAIN_B]) begin
                     bsel_q <= 1'b1;
                     boff_q <= '0;
                     buf_q  <= w3_q;
                  end else begin
                     last_q <= 1'b0;
                     st_q   <= S_WB;
                  end
               end else if (mem_req && mem_gnt) begin
                  boff_q <= boff_q + BSZ_W'(1);
                  rem_q  <= rem_q - REM_W'(1);
                  cnt_q  <= cnt_q + REM_W'(1);
               end
            end
            S_WB: if (mem_gnt) begin
               ptr_q <= nxt_ptr;
               if (last_q) begin
                  flush_q <= 1'b1;
                  if (!w1_q[NOIRQ_B]) ri_q <= 1'b1;
                  pst_q <= PS_WAIT;
                  bad_q <= 1'b0;
                  st_q  <= data_left ? S_DRAIN : S_IDLE;
               end else begin
                  first_q <= 1'b0;
                  widx_q  <= '0;
                  pst_q   <= PS_FETCH;
                  st_q    <= S_FETCH;
               end
            end
            S_DRAIN: begin
               if (!data_left)      st_q  <= S_IDLE;
               else if (byte_valid) rem_q <= rem_q - REM_W'(1);
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_WB_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st_q == S_WB) |-> !mem_wdata[OWN_B]);   // R6
   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st_q == S_XFER) |-> $countones(mem_be) == 1);   // R4
   AST_BYTE_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ready && st_q == S_XFER) |-> (mem_req && mem_we && mem_gnt));   // R12
   AST_RU_WITH_RI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ru_q) |-> ri_q);   // R3
   AST_SUSP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DRAIN) |-> !mem_req);   // R3
   AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_FETCH && mem_req) |-> (!mem_we && mem_addr[1:0] == 2'b00));   // R2

endmodule

// File: tb/rxring_dma_tb.sv
`timescale 1ns/1ps
module rxring_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_addr = 32'h100;
   logic        frm_valid = 1'b0;
   logic [13:0] frm_len = '0;
   logic        frm_ready, byte_valid, byte_ready;
   logic [7:0]  byte_data;
   logic        mem_req, mem_we, mem_gnt;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        ri_clr = 1'b0, ru_clr = 1'b0, flush_clr = 1'b0;
   logic [31:0] cur_desc, cur_buf;
   logic        ri, ru, flush;
   logic [2:0]  proc_state;

   logic [31:0] mem [0:255];
   logic        gnt_en = 1'b0;
   int          wr_cnt;
   logic        poke_we = 1'b0;
   logic [31:0] poke_a = '0, poke_d = '0;
   int          feed_idx, feed_n = 0, feed_start = 0;
   logic [7:0]  feed_seed = '0;
   logic [2:0]  plog [0:63];
   int          log_n;
   logic [2:0]  last_ps;
   int          n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   rxring_dma u_dut (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
      .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
      .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .ri_clr(ri_clr), .ru_clr(ru_clr), .flush_clr(flush_clr),
      .cur_desc(cur_desc), .cur_buf(cur_buf), .ri(ri), .ru(ru),
      .flush(flush), .proc_state(proc_state)
   );

   assign mem_gnt    = mem_req & gnt_en;
   assign mem_rdata  = mem[mem_addr[9:2]];
   assign byte_valid = (feed_idx < feed_n);
   assign byte_data  = feed_seed + 8'(feed_idx - feed_start);

   always @(posedge clk) begin
      gnt_en <= ~gnt_en;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 32'hEEEE_EEEE;
         wr_cnt   <= 0;
         feed_idx <= 0;
         log_n    <= 0;
         last_ps  <= 3'd0;
      end else begin
         if (poke_we) mem[poke_a[9:2]] <= poke_d;
         if (mem_req && mem_gnt && mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            wr_cnt <= wr_cnt + 1;
         end
         if (byte_valid && byte_ready) feed_idx <= feed_idx + 1;
         if (proc_state != last_ps) begin
            if (log_n < 64) plog[log_n] <= proc_state;
            log_n   <= log_n + 1;
            last_ps <= proc_state;
         end
      end
   end

   function automatic logic [7:0] rb(input int a);
      return mem[a >> 2][8*(a % 4) +: 8];
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic chk_bytes(input string rq, input int a, input int n, input logic [7:0] s);
      for (int i = 0; i < n; i++) chk(rq, 32'(rb(a + i)), 32'(s + 8'(i)));
   endtask

   task automatic chk_seq(input string rq, input int b, input int n, input logic [2:0] e [0:5]);
      chk(rq, 32'(log_n - b), 32'(n));
      for (int i = 0; i < n; i++) chk(rq, 32'(plog[b + i]), 32'(e[i]));
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      poke_we = 1'b1; poke_a = a; poke_d = d;
      @(posedge clk); #1 poke_we = 1'b0;
   endtask

   task automatic pdesc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input logic [31:0] w3);
      poke(a, w0); poke(a + 4, w1); poke(a + 8, w2); poke(a + 12, w3);
   endtask

   task automatic run_frame(input int len, input logic [7:0] seed);
      @(negedge clk);
      feed_start = feed_idx; feed_seed = seed; feed_n = feed_idx + len + 4;
      frm_len = 14'(len); frm_valid = 1'b1;
      do @(posedge clk); while (!frm_ready);
      @(negedge clk) frm_valid = 1'b0;
      do @(negedge clk); while (!frm_ready);
      @(posedge clk); @(negedge clk);
   endtask

   task automatic pulse_ri();    @(negedge clk) ri_clr = 1'b1;    @(negedge clk) ri_clr = 1'b0;    endtask
   task automatic pulse_ru();    @(negedge clk) ru_clr = 1'b1;    @(negedge clk) ru_clr = 1'b0;    endtask
   task automatic pulse_flush(); @(negedge clk) flush_clr = 1'b1; @(negedge clk) flush_clr = 1'b0; endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 state", 32'(proc_state), 32'd0);
      chk("R1 ri", 32'(ri), 32'd0);
      chk("R1 ru", 32'(ru), 32'd0);
      chk("R1 flush", 32'(flush), 32'd0);
      chk("R1 desc ptr", cur_desc, 32'd0);
      chk("R1 no request", 32'(mem_req), 32'd0);
      chk("R1 ready", 32'(frm_ready), 32'd1);
   endtask

   task automatic t_single();
      int b, w;
      b = log_n; w = wr_cnt;
      run_frame(20, 8'h10);
      chk_bytes("R4 R2 data", 32'h200, 24, 8'h10);
      chk("R5 buffer end untouched", 32'(rb(32'h218)), 32'hEE);
      chk("R6 status", mem[32'h100 >> 2], 32'h0018_0320);
      chk("R7 sequential", cur_desc, 32'h110);
      chk("R9 ri", 32'(ri), 32'd1);
      chk("R9 flush", 32'(flush), 32'd1);
      chk("R5 cur_buf", cur_buf, 32'h200);
      chk("R12 one write per byte", 32'(wr_cnt - w), 32'd25);
      chk_seq("R10 sequence", b, 4, '{3'd1, 3'd7, 3'd5, 3'd3, 3'd0, 3'd0});
   endtask

   task automatic t_two_buf();
      int w, f;
      pulse_ri();
      w = wr_cnt; f = feed_idx;
      run_frame(20, 8'h40);
      chk_bytes("R5 buf1", 32'h280, 8, 8'h40);
      chk("R5 buf1 limit", 32'(rb(32'h288)), 32'hEE);
      chk_bytes("R5 buf2", 32'h2C0, 6, 8'h48);
      chk("R5 buf2 limit", 32'(rb(32'h2C6)), 32'hEE);
      chk_bytes("R5 chained desc buf1", 32'h300, 10, 8'h4E);
      chk("R5 chained skips buf2", 32'(rb(32'h30A)), 32'hEE);
      chk("R6 first of two", mem[32'h110 >> 2], 32'h000E_0220);
      chk("R6 last of two", mem[32'h120 >> 2], 32'h0018_0120);
      chk("R7 chain pointer", cur_desc, 32'h140);
      chk("R9 no-irq flag", 32'(ri), 32'd0);
      chk("R5 cur_buf", cur_buf, 32'h300);
      chk("R12 bytes taken", 32'(feed_idx - f), 32'd24);
      chk("R12 writes", 32'(wr_cnt - w), 32'd26);
   endtask

   task automatic t_ring();
      pulse_ri();
      run_frame(4, 8'h80);
      chk_bytes("R4 ring data", 32'h380, 8, 8'h80);
      chk("R6 ring status", mem[32'h140 >> 2], 32'h0008_0320);
      chk("R7 end of ring", cur_desc, 32'h100);
      chk("R9 ri", 32'(ri), 32'd1);
   endtask

   task automatic t_unowned_start();
      int b, w, f;
      pulse_ri();
      b = log_n; w = wr_cnt; f = feed_idx;
      run_frame(6, 8'h90);
      chk("R3 ru", 32'(ru), 32'd1);
      chk("R3 ri", 32'(ri), 32'd1);
      chk("R3 suspended", 32'(proc_state), 32'd4);
      chk("R3 pointer kept", cur_desc, 32'h100);
      chk("R3 no write", 32'(wr_cnt - w), 32'd0);
      chk("R3 drained", 32'(feed_idx - f), 32'd10);
      chk("R3 buffer untouched", 32'(rb(32'h200)), 32'h10);
      chk_seq("R10 suspend sequence", b, 2, '{3'd1, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0});
      pulse_ru();
      chk("R11 ru cleared", 32'(ru), 32'd0);
      chk("R11 waiting", 32'(proc_state), 32'd3);
      pulse_ri();
      chk("R11 ri cleared", 32'(ri), 32'd0);
   endtask

   task automatic t_midframe_err();
      int f;
      pulse_flush();
      chk("R11 flush cleared", 32'(flush), 32'd0);
      poke(32'h100, 32'h8000_0000);
      poke(32'h104, 32'h0000_0008);
      f = feed_idx;
      run_frame(10, 8'hA0);
      chk_bytes("R8 data", 32'h200, 8, 8'hA0);
      chk("R8 stop at buffer end", 32'(rb(32'h208)), 32'h18);
      chk("R8 owned desc status", mem[32'h100 >> 2], 32'h0008_0220);
      chk("R8 error desc status", mem[32'h110 >> 2], 32'h0008_4100);
      chk("R8 pointer past", cur_desc, 32'h120);
      chk("R8 drained", 32'(feed_idx - f), 32'd14);
      chk("R9 ri", 32'(ri), 32'd1);
      chk("R9 flush", 32'(flush), 32'd1);
   endtask

   task automatic t_midframe_flush();
      int b;
      pdesc(32'h120, 32'h8000_0000, 32'h0000_0004, 32'h300, 32'h0);
      pdesc(32'h130, 32'h0, 32'h0, 32'h0, 32'h0);
      b = log_n;
      run_frame(2, 8'hC0);
      chk_bytes("R8 data", 32'h300, 4, 8'hC0);
      chk("R6 owned status", mem[32'h120 >> 2], 32'h0004_0220);
      chk("R8 flush masks error", mem[32'h130 >> 2], 32'h0004_0100);
      chk("R8 pointer past", cur_desc, 32'h140);
      chk_seq("R10 multi-desc sequence", b, 5, '{3'd1, 3'd7, 3'd1, 3'd5, 3'd3, 3'd0});
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      pdesc(32'h100, 32'h8000_0000, 32'h0000_0040, 32'h200, 32'h0);
      pdesc(32'h110, 32'h8000_0000, 32'h0000_3008, 32'h280, 32'h2C0);
      pdesc(32'h120, 32'h8000_0000, 32'h8100_0010, 32'h300, 32'h140);
      pdesc(32'h140, 32'h8000_0000, 32'h0200_0020, 32'h380, 32'h0);
      t_single();
      t_two_buf();
      t_ring();
      t_unowned_start();
      t_midframe_err();
      t_midframe_flush();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule